// File: doc/BRIEF.md
# Configurable Limit Alert Controller

This block drives the single alert output of a two-channel power monitor. Two alert slots can each be pointed at either channel and given a comparison type and a 16-bit limit. Each time a channel publishes a new set of results, every slot that watches that channel compares one of three values against its own limit: shunt voltage (signed), bus voltage (15-bit unsigned) or power (unsigned). The value compared depends on the slot's type. Each slot keeps its own flag.

The flag word also holds a conversion-ready flag and one energy-overflow flag per channel. The alert output is the OR of the slot flags, the masked conversion-ready flag and the masked overflow flags. Its active level is programmable. When latching is enabled, a slot flag stays set until software reads the flags and the condition has gone away.

The block sits between the measurement pipeline and the register file. Results and event strobes come in from the pipeline. Configuration fields and a flags-read strobe come from the register file.

Top module: `limit_alert_ctrl`

## Requirements
- R1: Type code 3'b001 flags when the slot channel's shunt word, taken as signed 16-bit, is greater than the limit. Type code 3'b010 flags when it is less than the limit. Equal values never flag.
- R2: Type code 3'b011 flags when bits 14:0 of the bus word are greater than bits 14:0 of the limit. Type code 3'b100 flags when they are less. Bit 15 of both the bus word and the limit is ignored.
- R3: Type code 3'b101 flags when the power word, taken as unsigned 16-bit, is greater than the limit.
- R4: A slot whose type code is 3'b000, 3'b110 or 3'b111, or whose channel select is 2'b10 or 2'b11, never changes its flag.
- R5: Channel select 2'b00 attaches a slot to channel 1 (bit 0 of `res_valid` and slice 0 of the result buses). Channel select 2'b01 attaches it to channel 2 (bit 1 and slice 1). A slot re-evaluates only on a `res_valid` pulse for its own channel.
- R6: With `latch_en` low, a slot flag takes the comparison result of each new publication of its channel, in the cycle after the pulse.
- R7: With `latch_en` high, a set slot flag stays set. It clears only when `flags_rd` is pulsed and the slot's most recent comparison result is false.
- R8: The alert output is high while active when `alert_pol` is 1. It is low while active when `alert_pol` is 0. When idle it sits at the opposite level, so with `alert_pol` = 0 and no source active after reset it reads 1.
- R9: A `conv_done` pulse sets the conversion-ready flag (flag bit 7). A `flags_rd` pulse clears it, and a set in the same cycle wins over the clear. The flag drives the alert only while `cvr_mask` is 1.
- R10: An `energy_ovf` pulse on a channel whose `ch_enable` bit is 1 sets that channel's overflow flag (bit 8 for channel 1, bit 9 for channel 2). An `acc_clr` pulse for that channel clears it, and a set in the same cycle wins. Overflow drives the alert only while `ovf_mask` is 1.
- R11: After reset every flag bit is 0. Slot 1 reports in flag bit 12 and slot 2 in bit 13. All bits not named in these requirements read 0.
- R12: Two slots on the same channel are evaluated independently. The alert is active whenever any slot flag, or any masked event flag, is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shunt_res | input | 32 | Shunt voltage words, channel c in bits 16c+15:16c |
| bus_res | input | 32 | Bus voltage words, same packing |
| pwr_res | input | 32 | Power words, same packing |
| res_valid | input | 2 | One-cycle pulse per channel: new results published |
| conv_done | input | 1 | One-cycle pulse: conversion sequence complete |
| energy_ovf | input | 2 | One-cycle pulse per channel: energy accumulator overflow |
| ch_enable | input | 2 | Per-channel enable |
| acc_clr | input | 2 | One-cycle pulse per channel: clear overflow flag |
| slot_chan | input | 4 | Channel select, slot s in bits 2s+1:2s |
| slot_type | input | 6 | Comparison type, slot s in bits 3s+2:3s |
| slot_limit | input | 32 | Limit, slot s in bits 16s+15:16s |
| latch_en | input | 1 | Latch slot flags until read |
| alert_pol | input | 1 | 1 = active-high alert, 0 = active-low |
| cvr_mask | input | 1 | Route conversion-ready onto the alert |
| ovf_mask | input | 1 | Route energy overflow onto the alert |
| flags_rd | input | 1 | One-cycle pulse: flag word has been read |
| alert_pin | output | 1 | Alert output |
| flags | output | 16 | Flag word |

## Verification
Every strobe (`res_valid`, `conv_done`, `energy_ovf`, `acc_clr`, `flags_rd`) is seen at one rising edge. Its effect on `flags` is due right after that edge, one register deep. `alert_pin` is combinational from the registered flags, `alert_pol` and the two masks. An alert caused by a strobe therefore follows in the same cycle as the flag. A change to the polarity or a mask shows on the pin with no clock edge at all. The bench drives on falling edges and samples one falling edge after each pulse. For the polarity and mask changes it samples a nanosecond after the change, which matches each of those latencies exactly.

// File: rtl/alert_pkg.sv
package alert_pkg;
    localparam int DW        = 16;
    localparam int NCH       = 2;
    localparam int NSLOT     = 2;
    localparam int CHSEL_W   = 2;
    localparam int TYPE_W    = 3;
    localparam int FLAG_W    = 16;
    localparam int SLOT_BIT0 = 12;
    localparam int OVF_BIT0  = 8;
    localparam int CVR_BIT   = 7;

    typedef enum logic [TYPE_W-1:0] {
        CMP_OFF      = 3'd0,
        CMP_SH_OVER  = 3'd1,
        CMP_SH_UNDER = 3'd2,
        CMP_BUS_OVER = 3'd3,
        CMP_BUS_UNDR = 3'd4,
        CMP_PWR_OVER = 3'd5,
        CMP_RSV6     = 3'd6,
        CMP_RSV7     = 3'd7
    } cmp_e;

    function automatic logic type_ok(input logic [TYPE_W-1:0] t);
        return (t >= 3'd1) && (t <= 3'd5);
    endfunction

    function automatic logic limit_hit(input cmp_e t,
                                       input logic [DW-1:0] sh,
                                       input logic [DW-1:0] bu,
                                       input logic [DW-1:0] pw,
                                       input logic [DW-1:0] lim);
        case (t)
            CMP_SH_OVER:  return $signed(sh) > $signed(lim);
            CMP_SH_UNDER: return $signed(sh) < $signed(lim);
            CMP_BUS_OVER: return bu[DW-2:0] > lim[DW-2:0];
            CMP_BUS_UNDR: return bu[DW-2:0] < lim[DW-2:0];
            CMP_PWR_OVER: return pw > lim;
            default:      return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/alert_slot.sv
module alert_slot
    import alert_pkg::*;
#(
    parameter int N_CH = NCH,
    parameter int W    = DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CHSEL_W-1:0]   chan,
    input  logic [TYPE_W-1:0]    typ,
    input  logic [W-1:0]         limit,
    input  logic [N_CH*W-1:0]    shunt_all,
    input  logic [N_CH*W-1:0]    bus_all,
    input  logic [N_CH*W-1:0]    pwr_all,
    input  logic [N_CH-1:0]      res_valid,
    input  logic                 latch_en,
    input  logic                 flags_rd,
    output logic                 flag
);
    typedef struct packed {
        logic cond;
        logic flag;
    } slot_st_t;

    slot_st_t     st_d, st_q;
    logic         hit_d, upd_d, active_d, res_d;
    logic [W-1:0] sh_d, bu_d, pw_d;

    always_comb begin
        hit_d = 1'b0;
        upd_d = 1'b0;
        sh_d  = '0;
        bu_d  = '0;
        pw_d  = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (chan == CHSEL_W'(c)) begin
                hit_d = 1'b1;
                upd_d = res_valid[c];
                sh_d  = shunt_all[c*W +: W];
                bu_d  = bus_all[c*W +: W];
                pw_d  = pwr_all[c*W +: W];
            end
        end
        active_d = hit_d && type_ok(typ);
        res_d    = limit_hit(cmp_e'(typ), sh_d, bu_d, pw_d, limit);

        st_d = st_q;
        if (active_d && upd_d) st_d.cond = res_d;
        if (latch_en) begin
            if (active_d && upd_d && res_d)
                st_d.flag = 1'b1;
            else if (active_d && flags_rd && !st_d.cond)
                st_d.flag = 1'b0;
        end else if (active_d && upd_d) begin
            st_d.flag = res_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R4: a slot with reserved configuration leaves its flag untouched
    p_reserved_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active_d |=> $stable(st_q.flag));

    // R7: in latched mode only a read can take the flag down
    p_latched_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && st_q.flag && !flags_rd) |=> st_q.flag);

    // R5: no publication on the watched channel means no change
    p_own_channel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_d && !flags_rd) |=> $stable(st_q.flag));
endmodule

// File: rtl/alert_event_flags.sv
module alert_event_flags
    import alert_pkg::*;
#(
    parameter int N_CH = NCH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            conv_done,
    input  logic            flags_rd,
    input  logic [N_CH-1:0] energy_ovf,
    input  logic [N_CH-1:0] ch_enable,
    input  logic [N_CH-1:0] acc_clr,
    output logic            cvr_flag,
    output logic [N_CH-1:0] ovf_flag
);
    typedef struct packed {
        logic            cvr;
        logic [N_CH-1:0] ovf;
    } ev_st_t;

    ev_st_t ev_d, ev_q;

    always_comb begin
        ev_d = ev_q;
        if (conv_done)     ev_d.cvr = 1'b1;
        else if (flags_rd) ev_d.cvr = 1'b0;
        for (int c = 0; c < N_CH; c++) begin
            if (energy_ovf[c] && ch_enable[c]) ev_d.ovf[c] = 1'b1;
            else if (acc_clr[c])               ev_d.ovf[c] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign cvr_flag = ev_q.cvr;
    assign ovf_flag = ev_q.ovf;

    // R9: completion always sets the ready flag
    p_cvr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> cvr_flag);

    // R9: a read without a completion clears it
    p_cvr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !conv_done) |=> !cvr_flag);

    for (genvar g = 0; g < N_CH; g++) begin : g_ovf_chk
        // R10: a disabled or quiet channel cannot raise its overflow flag
        p_ovf_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovf_flag[g] && !(energy_ovf[g] && ch_enable[g])) |=> !ovf_flag[g]);
    end
endmodule

// File: rtl/limit_alert_ctrl.sv
module limit_alert_ctrl
    import alert_pkg::*;
#(
    parameter int N_CH   = NCH,
    parameter int N_SLOT = NSLOT,
    parameter int W      = DW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH*W-1:0]          shunt_res,
    input  logic [N_CH*W-1:0]          bus_res,
    input  logic [N_CH*W-1:0]          pwr_res,
    input  logic [N_CH-1:0]            res_valid,
    input  logic                       conv_done,
    input  logic [N_CH-1:0]            energy_ovf,
    input  logic [N_CH-1:0]            ch_enable,
    input  logic [N_CH-1:0]            acc_clr,
    input  logic [N_SLOT*CHSEL_W-1:0]  slot_chan,
    input  logic [N_SLOT*TYPE_W-1:0]   slot_type,
    input  logic [N_SLOT*W-1:0]        slot_limit,
    input  logic                       latch_en,
    input  logic                       alert_pol,
    input  logic                       cvr_mask,
    input  logic                       ovf_mask,
    input  logic                       flags_rd,
    output logic                       alert_pin,
    output logic [FLAG_W-1:0]          flags
);
    logic [N_SLOT-1:0] slot_flag;
    logic              cvr_flag;
    logic [N_CH-1:0]   ovf_flag;
    logic              alert_act;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        alert_slot #(.N_CH(N_CH), .W(W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .chan      (slot_chan[s*CHSEL_W +: CHSEL_W]),
            .typ       (slot_type[s*TYPE_W +: TYPE_W]),
            .limit     (slot_limit[s*W +: W]),
            .shunt_all (shunt_res),
            .bus_all   (bus_res),
            .pwr_all   (pwr_res),
            .res_valid (res_valid),
            .latch_en  (latch_en),
            .flags_rd  (flags_rd),
            .flag      (slot_flag[s])
        );
    end

    alert_event_flags #(.N_CH(N_CH)) u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_done  (conv_done),
        .flags_rd   (flags_rd),
        .energy_ovf (energy_ovf),
        .ch_enable  (ch_enable),
        .acc_clr    (acc_clr),
        .cvr_flag   (cvr_flag),
        .ovf_flag   (ovf_flag)
    );

    always_comb begin
        flags = '0;
        for (int s = 0; s < N_SLOT; s++) flags[SLOT_BIT0 + s] = slot_flag[s];
        for (int c = 0; c < N_CH; c++)   flags[OVF_BIT0 + c]  = ovf_flag[c];
        flags[CVR_BIT] = cvr_flag;
        alert_act = (|slot_flag) || (cvr_mask && cvr_flag) || (ovf_mask && (|ovf_flag));
        alert_pin = alert_pol ? alert_act : !alert_act;
    end

    // R8: with nothing flagged the pin rests at the inactive level
    p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> (alert_pin == !alert_pol));

    // R12: any slot flag drives the pin active
    p_fault_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags[SLOT_BIT0 +: N_SLOT]) |-> (alert_pin == alert_pol));

    // R10: a masked-in overflow drives the pin active
    p_ovf_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_mask && (|flags[OVF_BIT0 +: N_CH])) |-> (alert_pin == alert_pol));
endmodule

// File: tb/limit_alert_ctrl_bench.sv
`timescale 1ns/1ps
module limit_alert_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] shunt_res = '0, bus_res = '0, pwr_res = '0;
    logic [1:0]  res_valid = '0, energy_ovf = '0, ch_enable = '0, acc_clr = '0;
    logic        conv_done = 1'b0;
    logic [3:0]  slot_chan = '0;
    logic [5:0]  slot_type = '0;
    logic [31:0] slot_limit = '0;
    logic        latch_en = 1'b0, alert_pol = 1'b0, cvr_mask = 1'b0, ovf_mask = 1'b0;
    logic        flags_rd = 1'b0;
    logic        alert_pin;
    logic [15:0] flags;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    limit_alert_ctrl u_limit_alert_ctrl (
        .clk(clk), .rst_n(rst_n), .shunt_res(shunt_res), .bus_res(bus_res),
        .pwr_res(pwr_res), .res_valid(res_valid), .conv_done(conv_done),
        .energy_ovf(energy_ovf), .ch_enable(ch_enable), .acc_clr(acc_clr),
        .slot_chan(slot_chan), .slot_type(slot_type), .slot_limit(slot_limit),
        .latch_en(latch_en), .alert_pol(alert_pol), .cvr_mask(cvr_mask),
        .ovf_mask(ovf_mask), .flags_rd(flags_rd), .alert_pin(alert_pin), .flags(flags)
    );

    // {type, limit, shunt, bus, power, expected slot-1 flag}, slot 1 on channel 1
    localparam logic [67:0] VEC [12] = '{
        {3'd1, 16'h0100, 16'h0200, 16'h0000, 16'h0000, 1'b1},
        {3'd1, 16'h0100, 16'h8300, 16'h0000, 16'h0000, 1'b0},
        {3'd2, 16'hFF00, 16'h8300, 16'h0000, 16'h0000, 1'b1},
        {3'd2, 16'hFF00, 16'h0010, 16'h0000, 16'h0000, 1'b0},
        {3'd1, 16'h0100, 16'h0100, 16'h0000, 16'h0000, 1'b0},
        {3'd3, 16'h1000, 16'h0000, 16'h9000, 16'h0000, 1'b0},
        {3'd3, 16'h1000, 16'h0000, 16'h1001, 16'h0000, 1'b1},
        {3'd4, 16'h9000, 16'h0000, 16'h0FFF, 16'h0000, 1'b1},
        {3'd4, 16'h1000, 16'h0000, 16'h7000, 16'h0000, 1'b0},
        {3'd5, 16'h8000, 16'h0000, 16'h0000, 16'h8001, 1'b1},
        {3'd5, 16'h7FFF, 16'h0000, 16'h0000, 16'hFFFF, 1'b1},
        {3'd5, 16'hFFFF, 16'h0000, 16'h0000, 16'h0001, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic publish(input int c, input logic [15:0] sh, input logic [15:0] bu,
                           input logic [15:0] pw);
        @(negedge clk);
        shunt_res[c*16 +: 16] = sh;
        bus_res[c*16 +: 16]   = bu;
        pwr_res[c*16 +: 16]   = pw;
        res_valid[c] = 1'b1;
        @(negedge clk);
        res_valid = '0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); flags_rd = 1'b1;
        @(negedge clk); flags_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset flags", flags, 16'h0000);
        chk("R8 reset pin idle high", {15'b0, alert_pin}, 16'h0001);

        // table walk on slot 1, channel 1, non-latched (R1 R2 R3 R6)
        for (int i = 0; i < 12; i++) begin
            slot_type[2:0]   = VEC[i][67:65];
            slot_limit[15:0] = VEC[i][64:49];
            publish(0, VEC[i][48:33], VEC[i][32:17], VEC[i][16:1]);
            chk($sformatf("R1/R2/R3/R6 vector %0d", i), {15'b0, flags[12]}, {15'b0, VEC[i][0]});
        end

        // R4: reserved types and channels never flag
        slot_type[2:0] = 3'd0;
        publish(0, 16'h7FFF, 16'h7FFF, 16'hFFFF);
        chk("R4 type 000", flags, 16'h0000);
        slot_type[2:0] = 3'd6;
        publish(0, 16'h7FFF, 16'h7FFF, 16'hFFFF);
        chk("R4 type 110", flags, 16'h0000);
        slot_type[2:0] = 3'd1; slot_limit[15:0] = 16'h0000; slot_chan[1:0] = 2'b10;
        publish(0, 16'h0100, 16'h0, 16'h0);
        chk("R4 channel 10", flags, 16'h0000);

        // R5 / R12: both slots on channel 2
        slot_chan = 4'b0101;
        slot_type = {3'd1, 3'd2};
        slot_limit = 32'h0000_0000;
        shunt_res[31:16] = 16'h0005;
        publish(0, 16'h0100, 16'h0, 16'h0);
        chk("R5 other channel ignored", flags, 16'h0000);
        publish(1, 16'h0005, 16'h0, 16'h0);
        chk("R5 own channel slot 2", flags, 16'h2000);
        chk("R12 pin active low", {15'b0, alert_pin}, 16'h0000);
        publish(1, 16'hFFFB, 16'h0, 16'h0);
        chk("R12 slots independent", flags, 16'h1000);

        // R8 polarity
        @(negedge clk); alert_pol = 1'b1; #1;
        chk("R8 active high", {15'b0, alert_pin}, 16'h0001);
        alert_pol = 1'b0; #1;
        chk("R8 active low", {15'b0, alert_pin}, 16'h0000);

        publish(1, 16'h0000, 16'h0, 16'h0);
        chk("R6 both clear", flags, 16'h0000);
        slot_type[5:3] = 3'd0;
        chk("R8 idle high", {15'b0, alert_pin}, 16'h0001);

        // R7 latching on slot 1, channel 1
        latch_en = 1'b1; slot_chan[1:0] = 2'b00; slot_type[2:0] = 3'd1; slot_limit[15:0] = 16'h0100;
        publish(0, 16'h0200, 16'h0, 16'h0);
        chk("R7 set", flags, 16'h1000);
        publish(0, 16'h0000, 16'h0, 16'h0);
        chk("R7 held after condition gone", flags, 16'h1000);
        pulse_rd();
        chk("R7 cleared by read", flags, 16'h0000);
        publish(0, 16'h0200, 16'h0, 16'h0);
        pulse_rd();
        chk("R7 read while condition present", flags, 16'h1000);
        publish(0, 16'h0000, 16'h0, 16'h0);
        chk("R7 still held", flags, 16'h1000);
        pulse_rd();
        chk("R7 final clear", flags, 16'h0000);
        latch_en = 1'b0;

        // R9 conversion ready
        cvr_mask = 1'b1;
        @(negedge clk); conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
        chk("R9 set", flags, 16'h0080);
        chk("R9 pin active", {15'b0, alert_pin}, 16'h0000);
        pulse_rd();
        chk("R9 read clears", flags, 16'h0000);
        @(negedge clk); conv_done = 1'b1; flags_rd = 1'b1;
        @(negedge clk); conv_done = 1'b0; flags_rd = 1'b0;
        chk("R9 set wins", flags, 16'h0080);
        cvr_mask = 1'b0; #1;
        chk("R9 masked off", {15'b0, alert_pin}, 16'h0001);
        pulse_rd();

        // R10 energy overflow
        ch_enable = 2'b01;
        @(negedge clk); energy_ovf = 2'b10; @(negedge clk); energy_ovf = 2'b00;
        chk("R10 disabled channel", flags, 16'h0000);
        @(negedge clk); energy_ovf = 2'b01; @(negedge clk); energy_ovf = 2'b00;
        chk("R10 channel 1 bit", flags, 16'h0100);
        chk("R10 unmasked pin idle", {15'b0, alert_pin}, 16'h0001);
        ovf_mask = 1'b1; #1;
        chk("R10 masked pin active", {15'b0, alert_pin}, 16'h0000);
        @(negedge clk); acc_clr = 2'b01; @(negedge clk); acc_clr = 2'b00;
        chk("R10 clear", flags, 16'h0000);
        ch_enable = 2'b11;
        @(negedge clk); energy_ovf = 2'b10; acc_clr = 2'b10;
        @(negedge clk); energy_ovf = 2'b00; acc_clr = 2'b00;
        chk("R10 channel 2 set wins", flags, 16'h0200);
        @(negedge clk); acc_clr = 2'b10; @(negedge clk); acc_clr = 2'b00;
        chk("R10 channel 2 clear", flags, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule